// File: doc/BRIEF.md
# Split-Register Hardware Stack Pointer

This block holds the 10-bit stack pointer of a small 8-bit processor core. Software sees the pointer as two byte-wide I/O registers. The low lane carries pointer bits 7:0. The high lane carries bits 9:8 in its two lowest bits, and its upper six bits always read as zero.

The core's control logic moves the pointer with four one-hot step strobes:

- single-byte push
- single-byte pop
- return-address push, for calls and interrupt entry
- return-address pop, for returns

Byte steps move the pointer by one and return-address steps move it by two. All arithmetic wraps modulo 1024 and no flag is raised.

The block also drives a data-memory access address for the current step. A push uses the pointer value before it is decremented. A pop uses the value after it is incremented. The external reset is asynchronous and active-low, and it is released synchronously inside the block.

Top module: `stack_ptr_unit`

## Requirements
- R1: While reset is asserted, and until two clock edges after it is released, the pointer is 0. Both I/O lanes then read 0.
- R2: A read at I/O address 0x3D returns pointer bits 7:0. A read at 0x3E returns {6'b0, pointer[9:8]}. Any other address reads 0x00. Reads are combinational from io_addr.
- R3: A write to address 0x3D loads pointer bits 7:0 from io_wdata on the clock edge and leaves bits 9:8 unchanged.
- R4: A write to address 0x3E loads pointer bits 9:8 from io_wdata[1:0] and leaves bits 7:0 unchanged. io_wdata[7:2] is ignored, so the high lane's bits 7:2 still read 0.
- R5: A single-byte push (push_byte_i) lowers the pointer by 1. mem_addr_o equals the pointer value before the step.
- R6: A single-byte pop (pop_byte_i) raises the pointer by 1. mem_addr_o equals the pointer plus 1, which is the new value.
- R7: A return-address push (push_ret_i) lowers the pointer by 2. mem_addr_o equals the pointer value before the step.
- R8: A return-address pop (pop_ret_i) raises the pointer by 2. mem_addr_o equals the pointer plus 1.
- R9: All steps wrap modulo 1024. For example, 0x000 minus 1 gives 0x3FF, and 0x3FF plus 2 gives 0x001.
- R10: When a step strobe and an I/O write fall in the same cycle, the step is applied and the write is dropped. At most one step strobe may be high in any cycle.
- R11: A write to any address other than 0x3D or 0x3E leaves the pointer unchanged. With no step and no write, the pointer holds its value and mem_addr_o equals the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 6 | I/O register address |
| io_wr_en | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data for io_addr |
| push_byte_i | input | 1 | Single-byte push strobe |
| pop_byte_i | input | 1 | Single-byte pop strobe |
| push_ret_i | input | 1 | Return-address push strobe |
| pop_ret_i | input | 1 | Return-address pop strobe |
| sp_o | output | 10 | Current pointer value |
| mem_addr_o | output | 10 | Data-memory address for the current step |

## Verification
Two functions can update the pointer in the same cycle: a software write to one of the two lanes and a step strobe from the core. The bench provokes this in directed cases, setting a lane write together with each kind of step. It also provokes it in random cycles, where the write strobe and a step are drawn independently. In every such cycle the pointer read after the edge must equal the step result computed from the old pointer, with no trace of the written byte in either lane.

// File: rtl/sp_pkg.sv
package sp_pkg;

  // Step command decoded from the one-hot strobes
  typedef enum logic [2:0] {
    STEP_IDLE  = 3'd0,
    STEP_PUSH1 = 3'd1,
    STEP_POP1  = 3'd2,
    STEP_PUSH2 = 3'd3,
    STEP_POP2  = 3'd4
  } step_e;

  function automatic logic step_is_pop(step_e s);
    return (s == STEP_POP1) || (s == STEP_POP2);
  endfunction

  function automatic logic step_is_wide(step_e s);
    return (s == STEP_PUSH2) || (s == STEP_POP2);
  endfunction

endpackage

// File: rtl/sp_rst_sync.sv
module sp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/sp_step_arith.sv
module sp_step_arith
  import sp_pkg::*;
#(
  parameter int PTR_W = 10
) (
  input  logic [PTR_W-1:0] sp_q,
  input  step_e            step,
  output logic             step_valid,
  output logic [PTR_W-1:0] sp_step,
  output logic [PTR_W-1:0] access_addr
);

  localparam logic [PTR_W-1:0] NARROW = PTR_W'(1);
  localparam logic [PTR_W-1:0] WIDE   = PTR_W'(2);

  logic [PTR_W-1:0] delta;
  logic [PTR_W-1:0] sp_up;
  logic [PTR_W-1:0] sp_down;
  logic [PTR_W-1:0] sp_plus1;

  always_comb begin
    delta    = step_is_wide(step) ? WIDE : NARROW;
    sp_up    = sp_q + delta;
    sp_down  = sp_q - delta;
    sp_plus1 = sp_q + NARROW;
  end

  always_comb begin
    step_valid  = (step != STEP_IDLE);
    sp_step     = step_is_pop(step) ? sp_up : sp_down;
    // Pushes address with the old value, pops with the incremented one
    access_addr = step_is_pop(step) ? sp_plus1 : sp_q;
  end

endmodule

// File: rtl/sp_io_lanes.sv
module sp_io_lanes #(
  parameter int              PTR_W     = 10,
  parameter int              DATA_W    = 8,
  parameter int              IO_AW     = 6,
  parameter logic [IO_AW-1:0] BASE_ADDR = 6'h3D
) (
  input  logic [IO_AW-1:0]  io_addr,
  input  logic              io_wr_en,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic [PTR_W-1:0]  sp_q,
  output logic              wr_hit,
  output logic [PTR_W-1:0]  sp_wr,
  output logic [DATA_W-1:0] io_rdata
);

  localparam int LANES = (PTR_W + DATA_W - 1) / DATA_W;
  localparam int PAD_W = LANES * DATA_W;

  logic [LANES-1:0] lane_hit;
  logic [PAD_W-1:0] sp_pad;

  always_comb begin
    sp_pad = PAD_W'(sp_q);
  end

  genvar k;
  generate
    for (k = 0; k < LANES; k++) begin : g_lane
      assign lane_hit[k] = (io_addr == (BASE_ADDR + IO_AW'(k)));
    end
  endgenerate

  // Bit-level merge: each pointer bit belongs to exactly one lane
  genvar b;
  generate
    for (b = 0; b < PTR_W; b++) begin : g_bit
      assign sp_wr[b] = (io_wr_en && lane_hit[b / DATA_W]) ? io_wdata[b % DATA_W] : sp_q[b];
    end
  endgenerate

  always_comb begin
    wr_hit = io_wr_en && (|lane_hit);
  end

  always_comb begin
    io_rdata = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_hit[i]) begin
        io_rdata = io_rdata | sp_pad[i*DATA_W +: DATA_W];
      end
    end
  end

endmodule

// File: rtl/stack_ptr_unit.sv
module stack_ptr_unit
  import sp_pkg::*;
#(
  parameter int               PTR_W     = 10,
  parameter int               DATA_W    = 8,
  parameter int               IO_AW     = 6,
  parameter logic [IO_AW-1:0] BASE_ADDR = 6'h3D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IO_AW-1:0]  io_addr,
  input  logic              io_wr_en,
  input  logic [DATA_W-1:0] io_wdata,
  output logic [DATA_W-1:0] io_rdata,
  input  logic              push_byte_i,
  input  logic              pop_byte_i,
  input  logic              push_ret_i,
  input  logic              pop_ret_i,
  output logic [PTR_W-1:0]  sp_o,
  output logic [PTR_W-1:0]  mem_addr_o
);

  logic             rst_sync_n;
  logic [PTR_W-1:0] sp_q;
  logic [PTR_W-1:0] sp_d;
  logic             sp_en;
  step_e            step;
  logic             step_valid;
  logic [PTR_W-1:0] sp_step;
  logic [PTR_W-1:0] access_addr;
  logic             wr_hit;
  logic [PTR_W-1:0] sp_wr;

  sp_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  // Strobes are one-hot by contract; the order here only fixes a value
  always_comb begin
    step = STEP_IDLE;
    if (push_byte_i) begin
      step = STEP_PUSH1;
    end else if (pop_byte_i) begin
      step = STEP_POP1;
    end else if (push_ret_i) begin
      step = STEP_PUSH2;
    end else if (pop_ret_i) begin
      step = STEP_POP2;
    end
  end

  sp_step_arith #(.PTR_W(PTR_W)) u_arith (
    .sp_q        (sp_q),
    .step        (step),
    .step_valid  (step_valid),
    .sp_step     (sp_step),
    .access_addr (access_addr)
  );

  sp_io_lanes #(
    .PTR_W     (PTR_W),
    .DATA_W    (DATA_W),
    .IO_AW     (IO_AW),
    .BASE_ADDR (BASE_ADDR)
  ) u_lanes (
    .io_addr  (io_addr),
    .io_wr_en (io_wr_en),
    .io_wdata (io_wdata),
    .sp_q     (sp_q),
    .wr_hit   (wr_hit),
    .sp_wr    (sp_wr),
    .io_rdata (io_rdata)
  );

  // Next state: a step outranks a software write
  always_comb begin
    sp_en = step_valid || wr_hit;
    sp_d  = step_valid ? sp_step : sp_wr;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      sp_q <= '0;
    end else if (sp_en) begin
      sp_q <= sp_d;
    end
  end

  assign sp_o       = sp_q;
  assign mem_addr_o = access_addr;

endmodule

// File: rtl/sp_checker.sv
module sp_checker #(
  parameter int               PTR_W     = 10,
  parameter int               DATA_W    = 8,
  parameter int               IO_AW     = 6,
  parameter logic [IO_AW-1:0] BASE_ADDR = 6'h3D
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IO_AW-1:0]  io_addr,
  input logic              io_wr_en,
  input logic [DATA_W-1:0] io_rdata,
  input logic              push_byte_i,
  input logic              pop_byte_i,
  input logic              push_ret_i,
  input logic              pop_ret_i,
  input logic [PTR_W-1:0]  sp_o,
  input logic [PTR_W-1:0]  mem_addr_o
);

  localparam logic [IO_AW-1:0] HI_ADDR = BASE_ADDR + IO_AW'(1);
  logic any_step;
  assign any_step = push_byte_i | pop_byte_i | push_ret_i | pop_ret_i;

  p_reset_zero_r1: assert property (@(posedge clk) !rst_n |=> sp_o == '0);

  p_one_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({push_byte_i, pop_byte_i, push_ret_i, pop_ret_i}));

  p_push1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    push_byte_i |=> sp_o == $past(sp_o) - PTR_W'(1));

  p_pop1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop_byte_i |=> sp_o == $past(sp_o) + PTR_W'(1));

  p_push2_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push_ret_i |=> sp_o == $past(sp_o) - PTR_W'(2));

  p_pop2_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pop_ret_i |=> sp_o == $past(sp_o) + PTR_W'(2));

  p_push_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (push_byte_i || push_ret_i) |-> mem_addr_o == sp_o);

  p_hi_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_addr == HI_ADDR) |-> io_rdata[DATA_W-1:PTR_W-DATA_W] == '0);

  p_lo_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr_en && io_addr == BASE_ADDR && !any_step)
      |=> sp_o[PTR_W-1:DATA_W] == $past(sp_o[PTR_W-1:DATA_W]));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!io_wr_en && !any_step) |=> $stable(sp_o));

endmodule

bind stack_ptr_unit sp_checker #(
  .PTR_W     (PTR_W),
  .DATA_W    (DATA_W),
  .IO_AW     (IO_AW),
  .BASE_ADDR (BASE_ADDR)
) u_sp_checker (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .io_addr     (io_addr),
  .io_wr_en    (io_wr_en),
  .io_rdata    (io_rdata),
  .push_byte_i (push_byte_i),
  .pop_byte_i  (pop_byte_i),
  .push_ret_i  (push_ret_i),
  .pop_ret_i   (pop_ret_i),
  .sp_o        (sp_o),
  .mem_addr_o  (mem_addr_o)
);

// File: tb/stack_ptr_unit_tb_top.sv
module stack_ptr_unit_tb_top;

  localparam logic [5:0] A_LO = 6'h3D;
  localparam logic [5:0] A_HI = 6'h3E;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] io_addr;
  logic       io_wr_en;
  logic [7:0] io_wdata;
  logic [7:0] io_rdata;
  logic       push_byte_i, pop_byte_i, push_ret_i, pop_ret_i;
  logic [9:0] sp_o;
  logic [9:0] mem_addr_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  logic [9:0] model = '0;

  always #2 clk = ~clk;

  stack_ptr_unit dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .io_addr     (io_addr),
    .io_wr_en    (io_wr_en),
    .io_wdata    (io_wdata),
    .io_rdata    (io_rdata),
    .push_byte_i (push_byte_i),
    .pop_byte_i  (pop_byte_i),
    .push_ret_i  (push_ret_i),
    .pop_ret_i   (pop_ret_i),
    .sp_o        (sp_o),
    .mem_addr_o  (mem_addr_o)
  );

  // op codes: 0 idle, 1 byte push, 2 byte pop, 3 return push, 4 return pop
  function automatic logic [9:0] f_next(logic [9:0] sp, int op, bit wr, logic [5:0] a, logic [7:0] d);
    case (op)
      1: return sp - 10'd1;
      2: return sp + 10'd1;
      3: return sp - 10'd2;
      4: return sp + 10'd2;
      default: begin
        if (wr && a == A_LO) return {sp[9:8], d};
        if (wr && a == A_HI) return {d[1:0], sp[7:0]};
        return sp;
      end
    endcase
  endfunction

  function automatic logic [9:0] f_addr(logic [9:0] sp, int op);
    return (op == 2 || op == 4) ? sp + 10'd1 : sp;
  endfunction

  function automatic logic [7:0] f_rd(logic [9:0] sp, logic [5:0] a);
    if (a == A_LO) return sp[7:0];
    if (a == A_HI) return {6'b0, sp[9:8]};
    return 8'h00;
  endfunction

  function automatic string f_tag(int op);
    case (op)
      1: return "R5";
      2: return "R6";
      3: return "R7";
      4: return "R8";
      default: return "R11";
    endcase
  endfunction

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int op, bit wr, logic [5:0] a, logic [7:0] d, string req);
    @(negedge clk);
    push_byte_i = (op == 1);
    pop_byte_i  = (op == 2);
    push_ret_i  = (op == 3);
    pop_ret_i   = (op == 4);
    io_wr_en    = wr;
    io_addr     = a;
    io_wdata    = d;
    #1;
    chk({req, " addr"}, int'(mem_addr_o), int'(f_addr(model, op)));
    chk("R2 read", int'(io_rdata), int'(f_rd(model, a)));
    @(posedge clk);
    #1;
    model = f_next(model, op, wr, a, d);
    push_byte_i = 1'b0; pop_byte_i = 1'b0; push_ret_i = 1'b0; pop_ret_i = 1'b0;
    io_wr_en = 1'b0;
    chk({req, " ptr"}, int'(sp_o), int'(model));
  endtask

  task automatic rd(logic [5:0] a, string req);
    @(negedge clk);
    io_addr = a;
    #1;
    chk(req, int'(io_rdata), int'(f_rd(model, a)));
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int op;
    bit wr;
    logic [5:0] a;
    logic [7:0] d;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    io_addr = A_LO; io_wr_en = 1'b0; io_wdata = '0;
    push_byte_i = 1'b0; pop_byte_i = 1'b0; push_ret_i = 1'b0; pop_ret_i = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset ptr", int'(sp_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 sync window", int'(sp_o), 0);
    repeat (2) @(posedge clk);
    rd(A_LO, "R1 lo lane");
    rd(A_HI, "R1 hi lane");

    // lane writes
    cyc(0, 1'b1, A_LO, 8'hAB, "R3");
    cyc(0, 1'b1, A_HI, 8'hFF, "R4");
    rd(A_HI, "R4 hi upper zero");
    cyc(0, 1'b1, A_LO, 8'h00, "R3");
    rd(A_LO, "R2 lo");
    rd(6'h3F, "R2 other addr");
    cyc(0, 1'b1, 6'h3C, 8'h55, "R11");
    cyc(0, 1'b1, 6'h3F, 8'h77, "R11");
    cyc(0, 1'b0, A_LO, 8'h00, "R11");

    // wrap corners
    cyc(0, 1'b1, A_HI, 8'h00, "R4");
    cyc(0, 1'b1, A_LO, 8'h00, "R3");
    cyc(1, 1'b0, A_LO, 8'h00, "R9 R5");
    cyc(4, 1'b0, A_LO, 8'h00, "R9 R8");
    cyc(3, 1'b0, A_LO, 8'h00, "R9 R7");
    cyc(2, 1'b0, A_LO, 8'h00, "R9 R6");
    cyc(3, 1'b0, A_HI, 8'h00, "R9 R7");

    // step against write in the same cycle
    cyc(1, 1'b1, A_LO, 8'h5A, "R10");
    cyc(2, 1'b1, A_HI, 8'hFE, "R10");
    cyc(3, 1'b1, A_LO, 8'h11, "R10");
    cyc(4, 1'b1, A_HI, 8'h02, "R10");

    for (int i = 0; i < 600; i++) begin
      op = int'($urandom_range(0, 4));
      wr = ($urandom_range(0, 2) == 0);
      case ($urandom_range(0, 3))
        0: a = A_LO;
        1: a = A_HI;
        2: a = A_LO;
        default: a = 6'($urandom_range(0, 63));
      endcase
      d = 8'($urandom);
      cyc(op, wr, a, d, (op != 0 && wr) ? "R10" : f_tag(op));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule